// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the write-command state machine of an asynchronous parallel NOR flash. Every signal is sampled on a system clock. A host drives chip enable, write and read strobes, an address and an 8-bit data byte. The block recognises the multi-write unlock sequences that start a program, and it runs a timed internal program operation. While that operation runs, it reports status on the read data bus and on a ready output.

Storage is a small array of byte cells. All cells read FFh after reset. Programming can only clear bits. A fast mode lets the host program each cell with two writes, with no unlock writes before each one. A secured region holds a computed 16-byte serial number. While that region is selected, it replaces array data on reads.

A write event is the first sampled clock edge at which chip enable and the write strobe are both low, after the write strobe was high on the previous edge. A read is active whenever chip enable and the read strobe are both low. When no read is active, dout is 00h.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset, ready is 1 and every cell reads FFh in array-read mode.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then data@address programs the cell at address bits [3:0]. Afterwards the interpreter is back in array read, so a further lone data write changes nothing.
- R3: A program stores old AND new. A bit cannot rise from 0 to 1. If the new data has a 1 where the cell holds 0, status bit 5 reads 1 for the whole busy period; otherwise it reads 0.
- R4: ready is 0 for exactly PROG_CYC clock edges after the data write of a program. During that time a read returns bit 7 as the complement of the written bit 7, with bits 4..0 at 0.
- R5: While busy, status bit 6 takes opposite values on two successive reads.
- R6: Every write received while busy is ignored, including a complete unlock-and-set-up sequence.
- R7: The writes AAh@555h, 55h@2AAh, 20h@555h enter bypass mode. In bypass mode each A0h write (any address) followed by data@address programs that cell. This repeats with no unlock writes.
- R8: In bypass mode, writes other than A0h and 90h are ignored, and the interpreter stays in bypass mode.
- R9: In bypass mode, 90h followed by F0h (addresses ignored) returns to array read. After that, A0h then data does not program.
- R10: AAh@555h, 55h@2AAh, 88h@555h select the secured region. A read then returns SN_BASE + i*SN_STEP (mod 256), where i is address bits [3:0]. AAh@555h, 55h@2AAh, 90h@555h, then 00h restores array reads.
- R11: The bypass entry sequence is refused while the secured region is selected. A following A0h then data does not program.
- R12: A write that does not match the expected cycle of a sequence (wrong data or wrong address) returns the interpreter to array read.
- R13: Asserting rst_n low during a program aborts it at once. ready goes to 1 with no clock edge, and the cell is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data: array, serial number or status |
| ready | output | 1 | 1 when no program operation is running |

## Verification
The bench programs every cell twice with arithmetic patterns. The first pass starts from erased cells and shows that the address is decoded. The second pass raises bits that are already 0, which separates a bitwise AND from a plain overwrite and from the error flag. The same per-cell sweep runs in bypass mode. A full sweep of the secured region compares each byte against the arithmetic serial formula. Corrupted sequences (a wrong unlock byte, a wrong unlock address, writes while busy, and writes after bypass reset or after a refused bypass entry) are each followed by a readback, which shows that no write reached the array.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

   typedef enum logic [3:0] {
      ST_READ,
      ST_UNL1,
      ST_UNL2,
      ST_PGM,
      ST_BYP,
      ST_BYP_PGM,
      ST_BYP_RST,
      ST_SEC_X,
      ST_BUSY
   } seq_state_t;

   localparam logic [7:0]  CMD_UNL1    = 8'hAA;
   localparam logic [7:0]  CMD_UNL2    = 8'h55;
   localparam logic [7:0]  CMD_PGM     = 8'hA0;
   localparam logic [7:0]  CMD_BYP_IN  = 8'h20;
   localparam logic [7:0]  CMD_SEC_IN  = 8'h88;
   localparam logic [7:0]  CMD_SEC_OUT = 8'h90;
   localparam logic [7:0]  CMD_SEC_END = 8'h00;
   localparam logic [7:0]  CMD_BRST1   = 8'h90;
   localparam logic [7:0]  CMD_BRST2   = 8'hF0;
   localparam logic [11:0] ADR_UNL1    = 12'h555;
   localparam logic [11:0] ADR_UNL2    = 12'h2AA;

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
   import nor_cmd_pkg::*;
#(
   parameter int AW       = 16,
   parameter int IDXW     = 4,
   parameter int PROG_CYC = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_evt,
   input  logic [AW-1:0]   addr,
   input  logic [7:0]      din,
   output logic            busy,
   output logic            sec_sel,
   output logic            launch,
   output logic            commit,
   output logic [IDXW-1:0] pgm_idx,
   output logic [7:0]      pgm_data
);

   localparam int            CW       = $clog2(PROG_CYC + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(PROG_CYC - 1);

   seq_state_t    st_q, st_d;
   logic          sec_q, sec_d;
   logic          ret_q, ret_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          at_a1, at_a2;

   assign at_a1   = (addr == AW'(ADR_UNL1));
   assign at_a2   = (addr == AW'(ADR_UNL2));
   assign busy    = (st_q == ST_BUSY);
   assign commit  = busy && (cnt_q == '0);
   assign launch  = wr_evt && ((st_q == ST_PGM) || (st_q == ST_BYP_PGM));
   assign sec_sel = sec_q;

   always_comb begin
      st_d  = st_q;
      sec_d = sec_q;
      ret_d = ret_q;
      cnt_d = cnt_q;
      if (launch) begin
         st_d  = ST_BUSY;
         cnt_d = CNT_LOAD;
         ret_d = (st_q == ST_BYP_PGM);
      end else if (busy) begin
         if (cnt_q == '0) st_d = ret_q ? ST_BYP : ST_READ;
         else             cnt_d = cnt_q - 1'b1;
      end else if (wr_evt) begin
         case (st_q)
            ST_READ: st_d = (at_a1 && din == CMD_UNL1) ? ST_UNL1 : ST_READ;
            ST_UNL1: st_d = (at_a2 && din == CMD_UNL2) ? ST_UNL2 : ST_READ;
            ST_UNL2: begin
               st_d = ST_READ;
               if (at_a1) begin
                  case (din)
                     CMD_PGM:     st_d = ST_PGM;
                     CMD_BYP_IN:  st_d = sec_q ? ST_READ : ST_BYP;
                     CMD_SEC_IN:  sec_d = 1'b1;
                     CMD_SEC_OUT: st_d = ST_SEC_X;
                     default:     st_d = ST_READ;
                  endcase
               end
            end
            ST_SEC_X: begin
               st_d = ST_READ;
               if (din == CMD_SEC_END) sec_d = 1'b0;
            end
            ST_BYP: begin
               if (din == CMD_PGM)        st_d = ST_BYP_PGM;
               else if (din == CMD_BRST1) st_d = ST_BYP_RST;
            end
            ST_BYP_RST: st_d = (din == CMD_BRST2) ? ST_READ : ST_BYP;
            default:    st_d = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_READ;
         sec_q    <= 1'b0;
         ret_q    <= 1'b0;
         cnt_q    <= '0;
         pgm_idx  <= '0;
         pgm_data <= '0;
      end else begin
         st_q  <= st_d;
         sec_q <= sec_d;
         ret_q <= ret_d;
         cnt_q <= cnt_d;
         if (launch) begin
            pgm_idx  <= addr[IDXW-1:0];
            pgm_data <= din;
         end
      end
   end

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
   parameter int         DEPTH   = 16,
   parameter int         IDXW    = 4,
   parameter logic [7:0] SN_BASE = 8'h3C,
   parameter logic [7:0] SN_STEP = 8'h59
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [IDXW-1:0]    pgm_idx,
   input  logic [7:0]         pgm_data,
   input  logic [IDXW-1:0]    rd_idx,
   input  logic [3:0]         sn_idx,
   output logic [7:0]         arr_word,
   output logic [7:0]         sn_word,
   output logic [DEPTH*8-1:0] cells_flat
);

   logic [DEPTH-1:0][7:0] cells_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells_q <= '1;
      end else if (commit) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (pgm_idx == IDXW'(i)) cells_q[i] <= cells_q[i] & pgm_data;
         end
      end
   end

   assign arr_word   = cells_q[rd_idx];
   assign sn_word    = SN_BASE + ({4'b0000, sn_idx} * SN_STEP);
   assign cells_flat = cells_q;

endmodule

// File: rtl/nor_status_path.sv
module nor_status_path #(
   parameter bit ERR_FLAG_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_act,
   input  logic       busy,
   input  logic       sec_sel,
   input  logic       launch,
   input  logic       err_hit,
   input  logic       pgm_d7,
   input  logic [7:0] arr_word,
   input  logic [7:0] sn_word,
   output logic [7:0] dout,
   output logic       tog,
   output logic       rd_end
);

   logic rd_q;
   logic err;

   assign rd_end = rd_q && !rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         tog  <= 1'b0;
      end else begin
         rd_q <= rd_act;
         if (busy && rd_end) tog <= ~tog;
      end
   end

   if (ERR_FLAG_EN) begin : g_err_flag
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      err_q <= 1'b0;
         else if (launch) err_q <= err_hit;
      end
      assign err = err_q;
   end else begin : g_no_err_flag
      assign err = 1'b0;
   end

   always_comb begin
      if (!rd_act)     dout = 8'h00;
      else if (busy)   dout = {~pgm_d7, tog, err, 5'b00000};
      else if (sec_sel) dout = sn_word;
      else             dout = arr_word;
   end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
   parameter int         AW          = 16,
   parameter int         DEPTH       = 16,
   parameter int         PROG_CYC    = 24,
   parameter logic [7:0] SN_BASE     = 8'h3C,
   parameter logic [7:0] SN_STEP     = 8'h59,
   parameter bit         ERR_FLAG_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    din,
   output logic [7:0]    dout,
   output logic          ready
);

   localparam int IDXW = $clog2(DEPTH);

   if (AW < 12) begin : g_chk_aw
      $error("nor_cmd_engine: AW must cover the unlock addresses");
   end
   if (DEPTH < 2 || (1 << IDXW) != DEPTH || DEPTH > 4096) begin : g_chk_depth
      $error("nor_cmd_engine: DEPTH must be a power of two from 2 to 4096");
   end
   if (PROG_CYC < 1) begin : g_chk_prog
      $error("nor_cmd_engine: PROG_CYC must be at least 1");
   end

   logic               we_q;
   logic               wr_evt;
   logic               rd_act;
   logic               busy, sec_sel, launch, commit;
   logic [IDXW-1:0]    pgm_idx;
   logic [7:0]         pgm_data;
   logic [7:0]         arr_word, sn_word;
   logic [DEPTH*8-1:0] cells_flat;
   logic               err_hit;
   logic               tog_bit, rd_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   assign wr_evt  = !ce_n && !we_n && we_q;
   assign rd_act  = !ce_n && !oe_n;
   assign ready   = !busy;
   assign err_hit = |(din & ~arr_word);

   nor_seq_fsm #(.AW(AW), .IDXW(IDXW), .PROG_CYC(PROG_CYC)) seq_i (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .addr(addr), .din(din),
      .busy(busy), .sec_sel(sec_sel), .launch(launch), .commit(commit),
      .pgm_idx(pgm_idx), .pgm_data(pgm_data)
   );

   nor_cell_array #(.DEPTH(DEPTH), .IDXW(IDXW), .SN_BASE(SN_BASE), .SN_STEP(SN_STEP)) arr_i (
      .clk(clk), .rst_n(rst_n), .commit(commit), .pgm_idx(pgm_idx),
      .pgm_data(pgm_data), .rd_idx(addr[IDXW-1:0]), .sn_idx(addr[3:0]),
      .arr_word(arr_word), .sn_word(sn_word), .cells_flat(cells_flat)
   );

   nor_status_path #(.ERR_FLAG_EN(ERR_FLAG_EN)) stat_i (
      .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .busy(busy),
      .sec_sel(sec_sel), .launch(launch), .err_hit(err_hit),
      .pgm_d7(pgm_data[7]), .arr_word(arr_word), .sn_word(sn_word),
      .dout(dout), .tog(tog_bit), .rd_end(rd_end)
   );

endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk #(
   parameter int DEPTH    = 16,
   parameter int PROG_CYC = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ready,
   input logic               wr_evt,
   input logic               rd_act,
   input logic               rd_end,
   input logic               tog,
   input logic [7:0]         dout,
   input logic [7:0]         lat_data,
   input logic [DEPTH*8-1:0] cells_flat
);

   localparam int BW = $clog2(PROG_CYC + 1) + 1;

   logic [BW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bcnt <= '0;
      else if (!ready) bcnt <= (bcnt == {BW{1'b1}}) ? bcnt : bcnt + 1'b1;
      else             bcnt <= '0;
   end

   // R4: a busy period starts only from a write event
   p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(wr_evt));

   // R4: a busy period lasts no longer than PROG_CYC edges
   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (bcnt < BW'(PROG_CYC)));

   // R4: status bit 7 is the complement of the latched bit 7
   p_busy_dq7_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && rd_act) |-> (dout[7] == ~lat_data[7]));

   // R3: no stored bit ever rises
   p_and_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cells_flat & ~$past(cells_flat)) == '0);

   // R5: a finished read while busy flips the toggle bit
   p_dq6_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && !ready) |=> (tog != $past(tog)));

   // R6: writes while busy do not disturb the latched data
   p_lat_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> $stable(lat_data));

endmodule

bind nor_cmd_engine nor_cmd_engine_chk #(.DEPTH(DEPTH), .PROG_CYC(PROG_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n), .ready(ready), .wr_evt(wr_evt), .rd_act(rd_act),
   .rd_end(rd_end), .tog(tog_bit), .dout(dout), .lat_data(pgm_data),
   .cells_flat(cells_flat)
);

// File: tb/nor_cmd_engine_tb_top.sv
module nor_cmd_engine_tb_top;

   localparam int         AW   = 16;
   localparam int         DEP  = 16;
   localparam int         PCYC = 12;
   localparam logic [7:0] SNB  = 8'h3C;
   localparam logic [7:0] SNS  = 8'h59;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic [7:0]    dout;
   logic          ready;

   int        n_chk = 0;
   int        n_err = 0;
   logic [7:0] model [DEP];

   always #4 clk = ~clk;

   nor_cmd_engine #(.AW(AW), .DEPTH(DEP), .PROG_CYC(PCYC), .SN_BASE(SNB),
                    .SN_STEP(SNS), .ERR_FLAG_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .dout(dout), .ready(ready)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      #2 d = dout;
      @(negedge clk);
      oe_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic unlock();
      bus_wr(16'h0555, 8'hAA);
      bus_wr(16'h02AA, 8'h55);
   endtask

   task automatic wait_rdy(output int n);
      n = 0;
      while (!ready && n < 10000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
   endtask

   task automatic check_all(input string req);
      logic [7:0] v;
      for (int i = 0; i < DEP; i++) begin
         bus_rd(AW'(i), v);
         chk(req, v, model[i]);
      end
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [7:0] v, s1, s2, p;
      int n;
      logic e;
      for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 ready", {7'b0, ready}, 8'h01);
      check_all("R1 erased");

      // R2 + R4 busy length, then address release
      unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h0003, 8'h5A);
      wait_rdy(n);
      chk("R4 busy length", 8'(n), 8'(PCYC));
      model[3] = 8'h5A;
      bus_rd(16'h0003, v); chk("R2 program", v, 8'h5A);
      bus_wr(16'h0003, 8'h00);
      bus_rd(16'h0003, v); chk("R2 back to read", v, 8'h5A);

      // R2 sweep pass 1 and R3 pass 2 with status reads
      for (int pass = 0; pass < 2; pass++) begin
         for (int i = 0; i < DEP; i++) begin
            p = (pass == 0) ? ((8'(i) * 8'h37) ^ 8'hC3) : ~(8'(i) * 8'h11);
            e = |(p & ~model[i]);
            unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(AW'(i), p);
            bus_rd(AW'(i), s1);
            bus_rd(AW'(i), s2);
            chk("R4 status dq7", {s1[7], s1[4:0]}, {~p[7], 5'b00000});
            chk("R3 status dq5", {7'b0, s1[5]}, {7'b0, e});
            chk("R5 dq6 toggle", {7'b0, s1[6] ^ s2[6]}, 8'h01);
            wait_rdy(n);
            model[i] = model[i] & p;
         end
         check_all(pass == 0 ? "R2 sweep" : "R3 and-only");
      end

      // R6 writes while busy ignored
      unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h0005, 8'hFF);
      unlock(); bus_wr(16'h0555, 8'hA0);
      wait_rdy(n);
      bus_wr(16'h0005, 8'h00);
      bus_rd(16'h0005, v); chk("R6 busy writes ignored", v, model[5]);

      // R13 hardware reset aborts program
      hw_reset();
      unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h0007, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1 chk("R13 ready on reset", {7'b0, ready}, 8'h01);
      @(negedge clk); rst_n = 1'b1;
      bus_rd(16'h0007, v); chk("R13 cell not written", v, 8'hFF);
      bus_wr(16'h0007, 8'h00);
      bus_rd(16'h0007, v); chk("R13 array read", v, 8'hFF);

      // R7 bypass sweep
      unlock(); bus_wr(16'h0555, 8'h20);
      for (int i = 0; i < DEP; i++) begin
         p = 8'(i) ^ 8'hE5;
         bus_wr(16'h1234, 8'hA0); bus_wr(AW'(16'h0100 + i), p);
         wait_rdy(n);
         model[i] = model[i] & p;
      end
      check_all("R7 bypass program");

      // R8 other writes ignored in bypass, mode kept
      unlock();
      bus_wr(16'h0002, 8'h00);
      bus_rd(16'h0002, v); chk("R8 ignored in bypass", v, model[2]);
      bus_wr(16'h0000, 8'hA0); bus_wr(16'h0002, 8'h0F);
      wait_rdy(n);
      model[2] = model[2] & 8'h0F;
      bus_rd(16'h0002, v); chk("R8 still bypass", v, model[2]);

      // R9 bypass reset
      bus_wr(16'h7777, 8'h90); bus_wr(16'h0001, 8'hF0);
      bus_wr(16'h0004, 8'hA0); bus_wr(16'h0004, 8'h00);
      @(negedge clk);
      chk("R9 ready", {7'b0, ready}, 8'h01);
      bus_rd(16'h0004, v); chk("R9 no program", v, model[4]);

      // R10 secured region sweep
      unlock(); bus_wr(16'h0555, 8'h88);
      for (int i = 0; i < 16; i++) begin
         bus_rd(AW'(16'h0100 + i), v);
         chk("R10 serial", v, SNB + 8'(i) * SNS);
      end
      // R11 bypass refused while secured
      unlock(); bus_wr(16'h0555, 8'h20);
      bus_wr(16'h0009, 8'hA0); bus_wr(16'h0009, 8'h00);
      @(negedge clk);
      chk("R11 ready", {7'b0, ready}, 8'h01);
      bus_rd(16'h0009, v); chk("R11 still secured", v, SNB + 8'd9 * SNS);
      unlock(); bus_wr(16'h0555, 8'h90); bus_wr(16'h0ABC, 8'h00);
      bus_rd(16'h0009, v); chk("R11 no program", v, model[9]);
      check_all("R10 exit secured");

      // R12 broken sequences
      bus_wr(16'h0555, 8'hAA); bus_wr(16'h02AA, 8'h12);
      bus_wr(16'h0555, 8'hA0); bus_wr(16'h0006, 8'h00);
      bus_rd(16'h0006, v); chk("R12 wrong data", v, model[6]);
      bus_wr(16'h0555, 8'hAA); bus_wr(16'h02AB, 8'h55);
      bus_wr(16'h0555, 8'hA0); bus_wr(16'h0006, 8'h00);
      bus_rd(16'h0006, v); chk("R12 wrong addr", v, model[6]);
      unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(16'h0006, 8'h00);
      wait_rdy(n);
      model[6] = 8'h00;
      bus_rd(16'h0006, v); chk("R12 recovers", v, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule